// File: doc/BRIEF.md
# Fault-Skipping Circular Queue

This block is a first-in first-out queue built on a ring of storage slots, meant for reorder-style or issue-style queues inside a core. Each slot has a "bad" bit in a repair map. A slot marked bad is never written and never read. The write and read pointers step over bad slots as they move around the ring, so the queue keeps its wrap-around order. Its usable capacity is the number of good slots.

Data enters and leaves on valid/ready streams. On the input side, a word moves when `in_valid` and `in_ready` are both high in the same cycle. `in_ready` falls while the queue holds as many words as it has good slots, and also during any cycle in which a map load is requested. On the output side, `out_valid` is high whenever the queue holds a word, and `out_data` shows the oldest word. That word leaves when `out_ready` is high. Both sides may transfer in the same cycle.

The repair map is loaded as a whole vector. A load takes effect only while the queue is empty. After a load, both pointers move to the lowest-numbered good slot. Offering a word to a full queue, or asking for a word from an empty queue, changes nothing and raises an error pulse one cycle later.

Top module: `hole_skip_fifo`

## Requirements
- R1: Reset state. After reset the map marks every slot good and the queue is empty. The outputs are `empty`=1, `full`=0, `unusable`=0, `out_valid`=0, `in_ready`=1, `push_err`=0 and `pop_err`=0.
- R2: Words leave in exactly the order they were accepted, whatever pattern of bad slots lies between them.
- R3: `full` is 1 exactly when the occupancy equals DEPTH minus the number of bad bits in the map. `empty` is 1 exactly when the occupancy is zero.
- R4: The pointers wrap circularly around the ring. Ordering and capacity hold over many laps of the ring.
- R5: `in_ready` = !`full` && !`map_we`. `out_valid` = !`empty`. A word moves only on valid && ready.
- R6: A push and a pop in the same cycle on a non-empty queue leave the occupancy unchanged.
- R7: `in_valid` while `full` is high stores nothing. `push_err` is 1 in the next cycle, for one cycle per offending cycle.
- R8: `out_ready` while `empty` is high removes nothing. `pop_err` is 1 in the next cycle, for one cycle per offending cycle.
- R9: A map load (`map_we`=1, bit i of `map_bits` = 1 marks slot i bad) is applied only when `empty` is 1, and is otherwise ignored. After an applied load, writing and reading restart from the lowest-index good slot.
- R10: If every slot is marked bad, `unusable`, `full` and `empty` are all 1, and every push is refused with `push_err`.
- R11: No word is ever written to, or presented from, a slot marked bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Queue can take a word this cycle |
| in_data | input | WIDTH | Input word |
| out_valid | output | 1 | Oldest word is available |
| out_ready | input | 1 | Consumer takes the oldest word |
| out_data | output | WIDTH | Oldest word |
| map_we | input | 1 | Request to load the repair map |
| map_bits | input | DEPTH | New map, 1 = slot bad |
| full | output | 1 | Occupancy equals the good-slot count |
| empty | output | 1 | Occupancy is zero |
| unusable | output | 1 | Every slot is marked bad |
| push_err | output | 1 | Pulse: a push was offered while full |
| pop_err | output | 1 | Pulse: a pop was requested while empty |

## Verification
The queue is driven with several repair maps:
- An all-good map, which checks plain ring behaviour.
- A scattered map, which checks skipping over isolated bad slots.
- A map with adjacent bad slots and bad slots at the ring ends, which checks multi-slot jumps across the wrap point.
- A map with a single good slot, which checks the degenerate ring.
- An all-bad map, which checks the unusable case.

Each map is exercised in three ways. Filling and draining separates errors in capacity from errors in ordering. Random mixed traffic over many laps of the ring separates pointer-wrap errors from errors in occupancy tracking. Map loads attempted while the queue holds data show whether the lock on the map is respected.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  function automatic int unsigned idx_bits(int unsigned d);
    return (d < 2) ? 1 : $clog2(d);
  endfunction
  function automatic int unsigned cnt_bits(int unsigned d);
    return $clog2(d + 1);
  endfunction
endpackage

// File: rtl/hsf_next_good.sv
module hsf_next_good #(
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic [IW-1:0]    cur,
  input  logic [DEPTH-1:0] bad,
  output logic [IW-1:0]    nxt,
  output logic             found
);
  // Search the ring after cur. The nearest good slot wins, because the
  // loop runs from the farthest offset down to the nearest one.
  always_comb begin
    nxt   = cur;
    found = 1'b0;
    for (int k = DEPTH; k >= 1; k--) begin
      if (!bad[(int'(cur) + k) % DEPTH]) begin
        nxt   = IW'((int'(cur) + k) % DEPTH);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hsf_popcnt.sv
module hsf_popcnt #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) ones = ones + CW'(vec[i]);
  end
endmodule

// File: rtl/hsf_store.sv
module hsf_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  parameter int IW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/hole_skip_fifo.sv
module hole_skip_fifo
  import hsf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  input  logic             map_we,
  input  logic [DEPTH-1:0] map_bits,
  output logic             full,
  output logic             empty,
  output logic             unusable,
  output logic             push_err,
  output logic             pop_err
);
  localparam int IW = idx_bits(DEPTH);
  localparam int CW = cnt_bits(DEPTH);

  logic [DEPTH-1:0] fmap;
  logic [IW-1:0]    head, tail, head_nx, tail_nx, first_good;
  logic [CW-1:0]    occ, bad_cnt, good_cnt;
  logic             head_f, tail_f, first_f;
  logic             do_push, do_pop, map_take;

  hsf_popcnt #(.N(DEPTH), .CW(CW)) u_bad_count (.vec(fmap), .ones(bad_cnt));

  hsf_next_good #(.DEPTH(DEPTH), .IW(IW)) u_tail_step (
    .cur(tail), .bad(fmap), .nxt(tail_nx), .found(tail_f));
  hsf_next_good #(.DEPTH(DEPTH), .IW(IW)) u_head_step (
    .cur(head), .bad(fmap), .nxt(head_nx), .found(head_f));
  // A search that starts after the last slot wraps round to slot 0 first.
  hsf_next_good #(.DEPTH(DEPTH), .IW(IW)) u_first (
    .cur(IW'(DEPTH - 1)), .bad(map_bits), .nxt(first_good), .found(first_f));

  hsf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IW(IW)) u_store (
    .clk(clk), .we(do_push), .waddr(tail), .wdata(in_data),
    .raddr(head), .rdata(out_data));

  assign good_cnt  = CW'(DEPTH) - bad_cnt;
  assign full      = (occ == good_cnt);
  assign empty     = (occ == '0);
  assign unusable  = (good_cnt == '0);
  assign in_ready  = !full && !map_we;
  assign out_valid = !empty;
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;
  assign map_take  = map_we && empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmap     <= '0;
      head     <= '0;
      tail     <= '0;
      occ      <= '0;
      push_err <= 1'b0;
      pop_err  <= 1'b0;
    end else begin
      push_err <= in_valid && full;
      pop_err  <= out_ready && empty;
      if (map_take) begin
        fmap <= map_bits;
        head <= first_f ? first_good : '0;
        tail <= first_f ? first_good : '0;
      end else begin
        if (do_push && tail_f) tail <= tail_nx;
        if (do_pop && head_f)  head <= head_nx;
        case ({do_push, do_pop})
          2'b10:   occ <= occ + 1'b1;
          2'b01:   occ <= occ - 1'b1;
          default: occ <= occ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hsf_check.sv
module hsf_check #(
  parameter int DEPTH = 8,
  parameter int IW    = 3,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             map_we,
  input logic             full,
  input logic             empty,
  input logic             unusable,
  input logic             push_err,
  input logic             pop_err,
  input logic [DEPTH-1:0] fmap,
  input logic [IW-1:0]    head,
  input logic [IW-1:0]    tail,
  input logic [CW-1:0]    occ
);
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready); // R5
  AST_PUSH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full) |=> push_err); // R7
  AST_POP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && empty) |=> pop_err); // R8
  AST_DEAD_RING: assert property (@(posedge clk) disable iff (!rst_n)
    unusable |-> (full && empty)); // R10
  AST_CLEAN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> !fmap[tail]); // R11
  AST_CLEAN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !fmap[head]); // R11
  AST_MAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (map_we && !empty) |=> $stable(fmap)); // R9
  AST_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid && out_ready) |=> $stable(occ)); // R6
endmodule

bind hole_skip_fifo hsf_check #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_hsf_check (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .map_we(map_we),
  .full(full), .empty(empty), .unusable(unusable), .push_err(push_err),
  .pop_err(pop_err), .fmap(fmap), .head(head), .tail(tail), .occ(occ));

// File: tb/tb_hole_skip_fifo.sv
module tb_hole_skip_fifo;
  localparam int DEPTH  = 8;
  localparam int WIDTH  = 16;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, map_we = 1'b0;
  logic [WIDTH-1:0] in_data = '0;
  logic [DEPTH-1:0] map_bits = '0;
  logic in_ready, out_valid, full, empty, unusable, push_err, pop_err;
  logic [WIDTH-1:0] out_data;

  hole_skip_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .map_we(map_we), .map_bits(map_bits),
    .full(full), .empty(empty), .unusable(unusable),
    .push_err(push_err), .pop_err(pop_err));

  always #(PERIOD/2) clk = ~clk;

  // Reference model: a queue of words, the repair map, and the error flags
  // expected in the coming cycle.
  logic [WIDTH-1:0] mq[$];
  logic [DEPTH-1:0] mmap = '0;
  logic m_perr = 1'b0, m_qerr = 1'b0;
  int n_cmp = 0, n_bad = 0;
  string phase = "R1 reset";
  logic [WIDTH-1:0] seq = 16'h1000;
  bit done = 0;

  task automatic chk(string sig, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", phase, sig, act, exp, $time);
    end
  endtask

  // Drive one cycle: set inputs, compare all outputs, advance the model.
  task automatic step(bit iv, bit ordy, bit mwe, logic [DEPTH-1:0] mb);
    int good;
    bit e_full, e_empty, e_ready, do_push, do_pop;
    in_valid = iv; in_data = seq; out_ready = ordy; map_we = mwe; map_bits = mb;
    #1;
    good    = DEPTH - $countones(mmap);
    e_full  = (mq.size() == good);
    e_empty = (mq.size() == 0);
    e_ready = !e_full && !mwe;
    chk("full (R3)", WIDTH'(full), WIDTH'(e_full));
    chk("empty (R3)", WIDTH'(empty), WIDTH'(e_empty));
    chk("unusable (R10)", WIDTH'(unusable), WIDTH'(good == 0));
    chk("in_ready (R5)", WIDTH'(in_ready), WIDTH'(e_ready));
    chk("out_valid (R5)", WIDTH'(out_valid), WIDTH'(!e_empty));
    chk("push_err (R7)", WIDTH'(push_err), WIDTH'(m_perr));
    chk("pop_err (R8)", WIDTH'(pop_err), WIDTH'(m_qerr));
    if (!e_empty) chk("out_data order (R2)", out_data, mq[0]);
    do_push = iv && e_ready;
    do_pop  = ordy && !e_empty;
    m_perr  = iv && e_full;
    m_qerr  = ordy && e_empty;
    if (do_pop) void'(mq.pop_front());
    if (do_push) begin mq.push_back(seq); seq = seq + 16'h0001; end
    if (mwe && e_empty) mmap = mb;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fill_drain();
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 0, '0);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 0, '0);
  endtask

  task automatic traffic(int n);
    for (int i = 0; i < n; i++) step(bit'($urandom % 3 != 0), bit'($urandom % 2), 0, '0);
    while (mq.size() != 0) step(0, 1, 0, '0);
  endtask

  task automatic load(logic [DEPTH-1:0] mb);
    step(0, 0, 1, mb);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state is compared by the first step
    step(0, 0, 0, '0);
    phase = "R3 R7 R8 all-good fill/drain";
    fill_drain();
    phase = "R9 map load while holding data is ignored";
    step(1, 0, 0, '0); step(1, 0, 0, '0);
    load('1);
    step(0, 0, 0, '0);
    step(0, 1, 0, '0); step(0, 1, 0, '0);
    phase = "R9 R11 scattered bad slots";
    load(8'b1010_0110);
    fill_drain();
    phase = "R4 R6 wrap traffic, scattered map";
    traffic(400);
    phase = "R4 R6 bad slots at ring ends";
    load(8'b1100_0011);
    fill_drain();
    traffic(400);
    phase = "R6 push and pop together";
    step(1, 0, 0, '0);
    for (int i = 0; i < 20; i++) step(1, 1, 0, '0);
    step(0, 1, 0, '0);
    phase = "R10 every slot bad";
    load('1);
    fill_drain();
    phase = "R11 single good slot";
    load(8'b1111_1101);
    fill_drain();
    traffic(200);
    phase = "R4 all good again";
    load('0);
    traffic(600);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule